// File: doc/BRIEF.md
# SPI Interrupt and DMA Request Unit

This unit turns the fill levels and event pulses of an SPI controller's transmit and receive FIFOs into one combined interrupt line and two DMA request lines. It keeps four interrupt sources at fixed bit positions. The transmit and receive level sources follow the FIFO levels directly. Receive overrun and receive timeout are sticky flags that software clears by writing ones.

Software reaches the unit through a small register port. The interrupt enables sit at 0x14, raw source status at 0x18, enabled (masked) status at 0x1C, the write-one-to-clear register at 0x20 and the DMA enables at 0x24. In all four interrupt registers, bit 0 is overrun, bit 1 is receive timeout, bit 2 is the RX level source and bit 3 is the TX level source. The receive timeout counts bit-period ticks from the shifter while the receive FIFO holds data and nothing moves in or out of it.

Top module: `spi_irq_dma_unit`

## Requirements
- R1: After reset the enable register, the DMA enable register and both sticky flags are 0, so `irq`, `tx_dma_req` and `rx_dma_req` are low whatever the FIFO levels.
- R2: A write to 0x14 stores bits [3:0] as enables (bit0 overrun, bit1 timeout, bit2 RX level, bit3 TX level). A read of 0x14 returns them, with all higher bits reading 0.
- R3: A read of 0x18 returns the raw sources: bit3 is 1 while `tx_level` <= 4, bit2 is 1 while `rx_level` >= 4, bit1 is the timeout flag and bit0 is the overrun flag.
- R4: A read of 0x1C returns the raw sources ANDed with the enables, and `irq` is 1 exactly when any of those bits is 1.
- R5: A one-cycle `rx_overrun` pulse sets the overrun flag on the next clock edge, and the flag stays set until it is cleared.
- R6: A write to 0x20 with bit0 set clears the overrun flag, and with bit1 set clears the timeout flag, on that clock edge. A flag that is set and cleared in the same cycle ends up set. A read of 0x20 returns 0.
- R7: Writes to 0x20 leave the TX and RX level sources (raw bits 3 and 2) unchanged.
- R8: The timeout flag sets on the 32nd `bit_tick` counted while `rx_level` is nonzero with no `rx_push` or `rx_pop`. Either of those, or an empty receive FIFO, restarts the count.
- R9: A write to 0x24 stores bit0 as the RX DMA enable and bit1 as the TX DMA enable. A read of 0x24 returns them.
- R10: `tx_dma_req` is 1 exactly while the TX DMA enable is set and `tx_level` < 8. `rx_dma_req` is 1 exactly while the RX DMA enable is set and `rx_level` != 0.
- R11: Writes to the status addresses 0x18 and 0x1C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_level | input | 4 | Transmit FIFO fill level, 0 to 8 |
| rx_level | input | 4 | Receive FIFO fill level, 0 to 8 |
| rx_overrun | input | 1 | Pulse: a received word was lost |
| rx_push | input | 1 | Pulse: a word entered the receive FIFO |
| rx_pop | input | 1 | Pulse: a word was read from the receive FIFO |
| bit_tick | input | 1 | One pulse per serial bit period |
| irq | output | 1 | Combined interrupt, OR of the enabled sources |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions check on every cycle that the DMA request lines never assert without their enable and FIFO condition. They also check that the overrun flag sets after a pulse and holds until a clear, that a clear with no competing pulse takes effect, that the interrupt never asserts with all enables off, and that an empty receive FIFO never raises the timeout. Only the bench scenarios can show the threshold values of the level sources, the exact 32-tick count with its restart on FIFO activity, register readback widths, precedence when a set and a clear meet in the same cycle, and that writes to the clear and status addresses leave the level sources and stored registers untouched.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int SRC_N   = 4;
    localparam int B_OVR   = 0;
    localparam int B_TMO   = 1;
    localparam int B_RXL   = 2;
    localparam int B_TXL   = 3;
    localparam int D_RXEN  = 0;
    localparam int D_TXEN  = 1;

    localparam logic [7:0] A_ENAB = 8'h14;
    localparam logic [7:0] A_RAW  = 8'h18;
    localparam logic [7:0] A_MSKD = 8'h1C;
    localparam logic [7:0] A_CLR  = 8'h20;
    localparam logic [7:0] A_DMA  = 8'h24;

    typedef struct packed {
        logic [SRC_N-1:0] enab;
        logic [1:0]       dma_en;
        logic             ovr;
        logic             tmo;
    } ctl_regs_t;
endpackage

// File: rtl/spi_rx_idle_timer.sv
module spi_rx_idle_timer #(
    parameter int LVL_W   = 4,
    parameter int LIMIT   = 32,
    localparam int CNT_W  = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             bit_tick,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        hit   = 1'b0;
        if (rx_level == '0 || rx_push || rx_pop) begin
            tmr_d.cnt = '0;
        end else if (bit_tick && tmr_q.cnt < CNT_W'(LIMIT)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            hit       = (tmr_q.cnt == CNT_W'(LIMIT - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              ovr_set,
    input  logic              tmo_set,
    input  logic              src_tx,
    input  logic              src_rx,
    output logic [SRC_N-1:0]  enab,
    output logic [1:0]        dma_en,
    output logic              ovr_flag,
    output logic              tmo_flag,
    output logic [SRC_N-1:0]  raw
);
    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr && addr == ADDR_W'(A_ENAB)) r_d.enab   = wdata[SRC_N-1:0];
        if (wr && addr == ADDR_W'(A_DMA))  r_d.dma_en = wdata[1:0];
        if (wr && addr == ADDR_W'(A_CLR)) begin
            if (wdata[B_OVR]) r_d.ovr = 1'b0;
            if (wdata[B_TMO]) r_d.tmo = 1'b0;
        end
        if (ovr_set) r_d.ovr = 1'b1;
        if (tmo_set) r_d.tmo = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        raw        = '0;
        raw[B_OVR] = r_q.ovr;
        raw[B_TMO] = r_q.tmo;
        raw[B_RXL] = src_rx;
        raw[B_TXL] = src_tx;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(A_ENAB): rdata[SRC_N-1:0] = r_q.enab;
            ADDR_W'(A_RAW):  rdata[SRC_N-1:0] = raw;
            ADDR_W'(A_MSKD): rdata[SRC_N-1:0] = raw & r_q.enab;
            ADDR_W'(A_DMA):  rdata[1:0]       = r_q.dma_en;
            default:         rdata            = '0;
        endcase
    end

    assign enab     = r_q.enab;
    assign dma_en   = r_q.dma_en;
    assign ovr_flag = r_q.ovr;
    assign tmo_flag = r_q.tmo;
endmodule

// File: rtl/spi_irq_dma_unit.sv
module spi_irq_dma_unit
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REG_W      = 32,
    parameter int DEPTH      = 8,
    parameter int RX_THRESH  = 4,
    parameter int TX_THRESH  = 4,
    parameter int IDLE_BITS  = 32,
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_overrun,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              bit_tick,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    logic             tmo_hit;
    logic             src_tx, src_rx;
    logic [SRC_N-1:0] enab_bits, raw_bits;
    logic [1:0]       dma_bits;
    logic             ovr_flag, tmo_flag;

    assign src_tx = (tx_level <= LVL_W'(TX_THRESH));
    assign src_rx = (rx_level >= LVL_W'(RX_THRESH));

    spi_rx_idle_timer #(.LVL_W(LVL_W), .LIMIT(IDLE_BITS)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .rx_push  (rx_push),
        .rx_pop   (rx_pop),
        .bit_tick (bit_tick),
        .hit      (tmo_hit)
    );

    spi_irq_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ovr_set  (rx_overrun),
        .tmo_set  (tmo_hit),
        .src_tx   (src_tx),
        .src_rx   (src_rx),
        .enab     (enab_bits),
        .dma_en   (dma_bits),
        .ovr_flag (ovr_flag),
        .tmo_flag (tmo_flag),
        .raw      (raw_bits)
    );

    assign irq        = |(raw_bits & enab_bits);
    assign tx_dma_req = dma_bits[D_TXEN] && (tx_level < LVL_W'(DEPTH));
    assign rx_dma_req = dma_bits[D_RXEN] && (rx_level != '0);
endmodule

// File: rtl/spi_irq_dma_chk.sv
module spi_irq_dma_chk
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 32,
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic              rx_overrun,
    input logic              irq,
    input logic              tx_dma_req,
    input logic              rx_dma_req,
    input logic [SRC_N-1:0]  enab_bits,
    input logic [1:0]        dma_bits,
    input logic              ovr_flag,
    input logic              tmo_flag
);
    logic clr_ovr;
    assign clr_ovr = reg_wr && reg_addr == ADDR_W'(A_CLR) && reg_wdata[B_OVR];

    // R5
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> ovr_flag);
    // R5
    ovr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr) |=> ovr_flag);
    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !rx_overrun) |=> !ovr_flag);
    // R4
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (enab_bits != '0));
    // R10
    tx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> (dma_bits[D_TXEN] && tx_level < LVL_W'(DEPTH)));
    // R10
    rx_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> (dma_bits[D_RXEN] && rx_level != '0));
    // R8
    tmo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0 && !tmo_flag) |=> !tmo_flag);
endmodule

bind spi_irq_dma_unit spi_irq_dma_chk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .rx_overrun (rx_overrun),
    .irq        (irq),
    .tx_dma_req (tx_dma_req),
    .rx_dma_req (rx_dma_req),
    .enab_bits  (enab_bits),
    .dma_bits   (dma_bits),
    .ovr_flag   (ovr_flag),
    .tmo_flag   (tmo_flag)
);

// File: tb/spi_irq_dma_unit_tb.sv
`timescale 1ns/1ps
module spi_irq_dma_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tx_level = 4'd0;
    logic [3:0]  rx_level = 4'd0;
    logic        rx_overrun = 1'b0;
    logic        rx_push = 1'b0;
    logic        rx_pop = 1'b0;
    logic        bit_tick = 1'b0;
    logic        irq, tx_dma_req, rx_dma_req;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    spi_irq_dma_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
        .rx_level(rx_level), .rx_overrun(rx_overrun), .rx_push(rx_push),
        .rx_pop(rx_pop), .bit_tick(bit_tick), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    // {tx_level, rx_level, raw_tx, raw_rx, tx_req, rx_req}
    localparam int NV = 6;
    localparam logic [11:0] VEC [NV] = '{
        {4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd4, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd5, 4'd4, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'd8, 4'd8, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd7, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'd3, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state, TX source high but nothing enabled
        rd(8'h14, d); check("R1 enables", d, 0);
        rd(8'h24, d); check("R1 dma enables", d, 0);
        check("R1 irq/dma", {irq, tx_dma_req, rx_dma_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {irq, tx_dma_req, rx_dma_req}, 0);

        // R2, R9 readback
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R2 enable width", d, 32'hF);
        wr(8'h14, 32'h0000_000C);
        rd(8'h14, d); check("R2 enable readback", d, 32'hC);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, d); check("R9 dma readback", d, 32'h3);

        // R3, R4, R10 level table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tx_level = VEC[i][11:8];
            rx_level = VEC[i][7:4];
            rd(8'h18, d);
            check("R3 raw levels", d, {28'd0, VEC[i][3], VEC[i][2], 2'b00});
            rd(8'h1C, d);
            check("R4 masked", d, {28'd0, VEC[i][3], VEC[i][2], 2'b00});
            check("R4 irq", irq, VEC[i][3] | VEC[i][2]);
            check("R10 requests", {tx_dma_req, rx_dma_req}, {VEC[i][1], VEC[i][0]});
        end

        // R10: enables gate requests
        tx_level = 4'd2; rx_level = 4'd2;
        wr(8'h24, 32'h1);
        check("R10 tx gated", {tx_dma_req, rx_dma_req}, 2'b01);
        wr(8'h24, 32'h2);
        check("R10 rx gated", {tx_dma_req, rx_dma_req}, 2'b10);

        // R11: writes to status addresses ignored
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R11 enables kept", d, 32'hC);
        rd(8'h24, d); check("R11 dma kept", d, 32'h2);
        rd(8'h18, d); check("R11 raw kept", d, 32'h8);

        // R7: clear does not touch level sources
        tx_level = 4'd0; rx_level = 4'd5;
        wr(8'h20, 32'hF);
        rd(8'h18, d); check("R7 levels survive clear", d, 32'hC);
        rd(8'h20, d); check("R6 clear reads zero", d, 0);

        // R5: overrun sticky
        tx_level = 4'd8; rx_level = 4'd0;
        wr(8'h14, 32'h1);
        check("R5 no irq yet", irq, 0);
        @(negedge clk); rx_overrun = 1'b1;
        @(negedge clk); rx_overrun = 1'b0;
        repeat (4) @(negedge clk);
        rd(8'h18, d); check("R5 overrun held", d, 32'h1);
        check("R5 irq", irq, 1);
        // R6 clear
        wr(8'h20, 32'h1);
        rd(8'h18, d); check("R6 overrun cleared", d, 0);
        check("R6 irq low", irq, 0);
        // R6 set wins over clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h1; rx_overrun = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; rx_overrun = 1'b0;
        rd(8'h18, d); check("R6 set beats clear", d, 32'h1);
        wr(8'h20, 32'h1);

        // R8: receive timeout
        wr(8'h14, 32'h2);
        rx_level = 4'd0;
        ticks(40);
        rd(8'h18, d); check("R8 empty never times out", d, 0);
        rx_level = 4'd1;
        @(negedge clk); rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
        ticks(20);
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
        ticks(31);
        rd(8'h18, d); check("R8 31 ticks not yet", d, 0);
        ticks(1);
        rd(8'h18, d); check("R8 32nd tick sets", d, 32'h2);
        check("R8 irq", irq, 1);
        wr(8'h20, 32'h2);
        rd(8'h18, d); check("R6 timeout cleared", d, 0);
        ticks(5);
        rd(8'h18, d); check("R8 no re-fire without activity", d, 0);

        summary();
    end
endmodule